// File: doc/BRIEF.md
# Sensor Temperature to Signed BCD Converter

This block takes one raw reading from a digital temperature sensor and returns it as a sign flag plus packed BCD digits, ready for a character display or a serial text link. The reading is a 16-bit fixed-point word with four fractional bits, so one count is 1/16 of a degree. The upper five bits carry the sign extension and the lower eleven bits carry the value.

The block finds the sign and takes the two's-complement magnitude of the low field. It multiplies the magnitude by 625, so each 1/16-degree step becomes a whole number of ten-thousandths of a degree. A sequential shift-and-add-3 engine then converts that 21-bit product into seven decimal digits, one shift per clock.

Readings enter on a valid/ready stream and results leave on a second valid/ready stream. The input side accepts a word only while the block is idle. The output side holds its data until the consumer takes it. Back-pressure on the output therefore stalls the input, and at most one reading is in flight at any time.

Top module: `temp_bcd_conv`

## Requirements
- R1: The reading is negative when any of bits [15:11] of `in_raw` is 1, and non-negative otherwise.
- R2: The magnitude is `in_raw[10:0]` for a non-negative reading. For a negative reading it is `(~in_raw[10:0] + 1)` taken modulo 2^11.
- R3: The digits on `out_bcd` give the decimal value of magnitude × 625, which is the temperature in ten-thousandths of a degree.
- R4: Digit k sits at `out_bcd[4k+3:4k]`, with k=0 the least significant. Digits 0 to 3 are the fraction (ten-thousandths up to tenths), digit 4 the ones at [19:16], digit 5 the tens at [23:20] and digit 6 the hundreds at [27:24]. Every digit is 0 to 9 while `out_valid` is high.
- R5: `out_sign` is 1 only for a negative reading with a non-zero magnitude. A zero result, including codes such as 16'hF800, is reported with `out_sign` 0.
- R6: `in_ready` is high only while the block is idle. A word is accepted on a rising edge where `in_valid` and `in_ready` are both high, and `in_ready` is low from that edge until the result has been handed off.
- R7: `out_valid` first reads high after the 22nd rising edge following the accepting edge, which is the product width plus one.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_sign` and `out_bcd` hold their values. The handoff completes on an edge with `out_ready` high, after which `out_valid` is low and `in_ready` is high.
- R9: After reset, `in_ready` is 1, `out_valid` is 0, `out_sign` is 0 and `out_bcd` is 0.
- R10: Changes on `in_raw` and `in_valid` while `in_ready` is low have no effect on the result being produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Raw reading present |
| in_ready | output | 1 | Block idle and able to take a reading |
| in_raw | input | 16 | Raw sensor word, 1/16 degree per count |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_sign | output | 1 | 1 for a negative, non-zero temperature |
| out_bcd | output | 28 | Seven packed BCD digits, fraction in the low four |

## Verification
The bench builds the block with its default parameters: a 16-bit word, an 11-bit magnitude and a scale of 625. This gives a 21-bit product and seven digits, so the largest code 16'h07FF (127.9375) exercises the hundreds digit. The sign-extension-only codes 16'hF800 and 16'h0800 reach the zero-is-positive rule. Random output stalls of zero to three cycles and random input noise during conversion cover the handshake rules alongside the numeric ones.

// File: rtl/temp_bcd_pkg.sv
package temp_bcd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_HOLD = 2'd2
  } conv_state_e;

  // Number of decimal digits needed to print a non-negative value.
  function automatic int dec_digits(input longint value);
    longint v;
    int     n;
    v = value;
    n = 1;
    while (v >= 10) begin
      v = v / 10;
      n = n + 1;
    end
    return n;
  endfunction

  // Correction step applied to one BCD digit before a left shift.
  function automatic logic [3:0] fix_digit(input logic [3:0] d);
    return (d >= 4'd5) ? d + 4'd3 : d;
  endfunction

endpackage

// File: rtl/temp_sign_mag.sv
module temp_sign_mag #(
  parameter int RAW_W = 16,
  parameter int MAG_W = 11
) (
  input  logic [RAW_W-1:0] raw,
  output logic             neg,
  output logic [MAG_W-1:0] mag
);
  logic [MAG_W-1:0] low;

  assign low = raw[MAG_W-1:0];
  assign neg = |raw[RAW_W-1:MAG_W];
  assign mag = neg ? MAG_W'(~low + 1'b1) : low;

endmodule

// File: rtl/temp_scale.sv
module temp_scale #(
  parameter int MAG_W  = 11,
  parameter int SCALE  = 625,
  parameter int PROD_W = 21
) (
  input  logic [MAG_W-1:0]  mag,
  output logic [PROD_W-1:0] prod
);
  localparam int SB = $clog2(SCALE + 1);

  logic [PROD_W-1:0] term [SB];

  for (genvar i = 0; i < SB; i++) begin : g_term
    if (((SCALE >> i) % 2) == 1) begin : g_on
      assign term[i] = PROD_W'(mag) << i;
    end else begin : g_off
      assign term[i] = '0;
    end
  end

  always_comb begin
    prod = '0;
    for (int i = 0; i < SB; i++) begin
      prod = prod + term[i];
    end
  end

endmodule

// File: rtl/bcd_dabble_seq.sv
module bcd_dabble_seq
  import temp_bcd_pkg::*;
#(
  parameter int BIN_W = 21,
  parameter int NDIG  = 7,
  localparam int BCD_W = 4 * NDIG,
  localparam int CNT_W = $clog2(BIN_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BIN_W-1:0] bin_in,
  output logic             busy,
  output logic             done,
  output logic [BCD_W-1:0] bcd
);
  logic [BIN_W-1:0] bin_sr;
  logic [BCD_W-1:0] bcd_sr;
  logic [BCD_W-1:0] adj;
  logic [CNT_W-1:0] cnt;

  for (genvar d = 0; d < NDIG; d++) begin : g_fix
    assign adj[4*d +: 4] = fix_digit(bcd_sr[4*d +: 4]);
  end

  assign busy = (cnt != '0);
  assign bcd  = bcd_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_sr <= '0;
      bcd_sr <= '0;
      cnt    <= '0;
      done   <= 1'b0;
    end else if (start) begin
      bin_sr <= bin_in;
      bcd_sr <= '0;
      cnt    <= CNT_W'(BIN_W);
      done   <= 1'b0;
    end else if (busy) begin
      bcd_sr <= {adj[BCD_W-2:0], bin_sr[BIN_W-1]};
      bin_sr <= bin_sr << 1;
      cnt    <= cnt - 1'b1;
      done   <= (cnt == CNT_W'(1));
    end else begin
      done   <= 1'b0;
    end
  end

  // R6
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !start);

endmodule

// File: rtl/temp_bcd_conv.sv
module temp_bcd_conv
  import temp_bcd_pkg::*;
#(
  parameter int RAW_W = 16,
  parameter int MAG_W = 11,
  parameter int SCALE = 625,
  localparam longint MAX_PROD = longint'((1 << MAG_W) - 1) * longint'(SCALE),
  localparam int PROD_W = $clog2(MAX_PROD + 1),
  localparam int NDIG   = dec_digits(MAX_PROD),
  localparam int BCD_W  = 4 * NDIG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [RAW_W-1:0] in_raw,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_sign,
  output logic [BCD_W-1:0] out_bcd
);
  conv_state_e       state;
  logic              neg;
  logic [MAG_W-1:0]  mag;
  logic [PROD_W-1:0] prod;
  logic              start;
  logic              dab_busy;
  logic              dab_done;
  logic              sign_q;

  temp_sign_mag #(.RAW_W(RAW_W), .MAG_W(MAG_W)) u_sign (
    .raw (in_raw),
    .neg (neg),
    .mag (mag)
  );

  temp_scale #(.MAG_W(MAG_W), .SCALE(SCALE), .PROD_W(PROD_W)) u_scale (
    .mag  (mag),
    .prod (prod)
  );

  bcd_dabble_seq #(.BIN_W(PROD_W), .NDIG(NDIG)) u_dab (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .bin_in (prod),
    .busy   (dab_busy),
    .done   (dab_done),
    .bcd    (out_bcd)
  );

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_HOLD);
  assign start     = in_ready && in_valid;
  assign out_sign  = sign_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      sign_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (in_valid) begin
          sign_q <= neg && (|mag);
          state  <= ST_CONV;
        end
        ST_CONV: if (dab_done) state <= ST_HOLD;
        ST_HOLD: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bcd) && $stable(out_sign));

  // R5
  zero_positive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sign |-> out_bcd != '0);

  // R6
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dab_busy |-> !in_ready && !out_valid);

  for (genvar d = 0; d < NDIG; d++) begin : g_dchk
    // R4
    digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_bcd[4*d +: 4] <= 4'd9);
  end

endmodule

// File: tb/tb_temp_bcd_conv.sv
`timescale 1ns/1ps
module tb_temp_bcd_conv;
  localparam int NDIG  = 7;
  localparam int BCD_W = 4 * NDIG;
  localparam int LAT   = 22;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [15:0]      in_raw = '0;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic             out_sign;
  logic [BCD_W-1:0] out_bcd;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  temp_bcd_conv dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_raw(in_raw), .out_valid(out_valid), .out_ready(out_ready),
    .out_sign(out_sign), .out_bcd(out_bcd)
  );

  function automatic logic [BCD_W:0] model(input logic [15:0] raw);
    logic        neg;
    int          mag;
    int          p;
    logic [BCD_W-1:0] b;
    neg = (raw[15:11] != 5'd0);
    mag = neg ? ((~int'(raw[10:0]) + 1) & 32'h7FF) : int'(raw[10:0]);
    p   = mag * 625;
    b   = '0;
    for (int k = 0; k < NDIG; k++) begin
      b[4*k +: 4] = 4'(p % 10);
      p = p / 10;
    end
    return {neg && (mag != 0), b};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [15:0] raw, input int stall);
    logic [BCD_W:0] e;
    int n;
    e = model(raw);
    @(negedge clk);
    check(in_ready === 1'b1, "R6 idle ready", 32'(in_ready), 32'd1);
    in_valid = 1'b1;
    in_raw   = raw;
    @(posedge clk);
    @(negedge clk);
    check(in_ready === 1'b0, "R6 busy not ready", 32'(in_ready), 32'd0);
    // R10: noise on the input while busy
    in_raw   = 16'($urandom());
    in_valid = 1'($urandom());
    n = 0;
    while (out_valid !== 1'b1 && n < 100) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (out_valid !== 1'b1) begin
        in_raw   = 16'($urandom());
        in_valid = 1'($urandom());
      end
    end
    in_valid = 1'b0;
    check(n == LAT, "R7 latency", 32'(n), 32'(LAT));
    check(out_bcd === e[BCD_W-1:0], "R3 R4 R10 digits", 32'(out_bcd), 32'(e[BCD_W-1:0]));
    check(out_sign === e[BCD_W], "R1 R2 R5 sign", 32'(out_sign), 32'(e[BCD_W]));
    for (int s = 0; s < stall; s++) begin
      @(posedge clk);
      @(negedge clk);
      check(out_valid === 1'b1 && out_bcd === e[BCD_W-1:0] && out_sign === e[BCD_W]
            && in_ready === 1'b0, "R8 hold", 32'(out_bcd), 32'(e[BCD_W-1:0]));
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    check(out_valid === 1'b0 && in_ready === 1'b1, "R8 handoff",
          {30'd0, out_valid, in_ready}, 32'd1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R9
    check(in_ready === 1'b1 && out_valid === 1'b0 && out_sign === 1'b0 && out_bcd === '0,
          "R9 reset", 32'(out_bcd), 32'd0);
    rst_n = 1'b1;
    run_one(16'h0191, 0);  // +25.0625
    run_one(16'hFF5E, 2);  // -10.125
    run_one(16'h0000, 1);  // zero
    run_one(16'h07D0, 0);  // +125
    run_one(16'hFC90, 3);  // -55
    run_one(16'h07FF, 1);  // largest, hundreds digit
    run_one(16'hF800, 0);  // R5 negative code with zero magnitude
    run_one(16'h0800, 0);  // R1 single sign bit, zero magnitude
    run_one(16'hFFFF, 2);  // -0.0625
    run_one(16'h0001, 0);  // +0.0625
    for (int i = 0; i < 40; i++) begin
      logic [15:0] r;
      if (i % 2 == 0) r = 16'($urandom());
      else r = 16'($signed(int'($urandom_range(0, 2880)) - 880));
      run_one(r, int'($urandom_range(0, 3)));
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule